// File: doc/BRIEF.md
# DDR3 Write Burst Timing Sequencer

This controller-side block turns each accepted WRITE command into a write burst placed at the write latency. The latency is the CAS write latency plus the additive latency, both set by parameters. The burst length is chosen per command. A two-bit burst mode setting either fixes the burst at eight beats or lets the command's A12 bit choose between a four-beat chop and a full eight-beat burst. Data is modelled as two beats per clock, one on the rising edge and one on the falling edge. For each data clock the block reports the column addresses of both beats, and it drives the enables for the DQ outputs, the strobe output, the preamble and the postamble.

After the last data clock of a write, two programmable counters run: write recovery and write-to-read turnaround. Two flags tell the command scheduler when a PRECHARGE or a READ may be issued. Writes spaced exactly four clocks apart stream seamlessly. The block rejects writes that come too close together, and writes issued while a reserved mode is programmed.

Top module: `wr_burst_sched`

## Requirements
- R1: A WRITE sampled at clock edge k has its first data clock in the cycle that begins at edge k+WL, where WL = CWL + AL (default 5).
- R2: With `cfgBurstMode` = 2'b00 every accepted write is 8 beats: `dqOe` is high for 4 consecutive clocks, whatever the value of `wrChopBit`.
- R3: With `cfgBurstMode` = 2'b01, `wrChopBit` = 0 gives a 4-beat chop (`dqOe` high for 2 clocks) and `wrChopBit` = 1 gives an 8-beat burst (4 clocks).
- R4: On data clock i of a burst (i counted from 0), `beatColRise` = col + 2i and `beatColFall` = col + 2i + 1, both modulo 2^COL_W, where col is the command's `wrCol`. Both outputs read 0 when `dqOe` is low.
- R5: `preambleEn` is high for the one clock just before a data clock that follows a clock without data. `postambleEn` is high for the one clock just after a data clock that is followed by a clock without data. `dqsOe` = `dqOe` | `preambleEn` | `postambleEn`.
- R6: Two 8-beat writes sampled 4 clocks apart give 8 consecutive data clocks carrying 16 beats, with no postamble or preamble at the boundary.
- R7: A WRITE sampled fewer than 4 clocks after the last accepted WRITE is not scheduled, and `wrReject` pulses in the cycle after that edge.
- R8: A WRITE sampled while `cfgBurstMode[1]` is 1 (2'b10 or 2'b11, reserved) is not scheduled, and `modeErr` pulses in the cycle after that edge (`wrReject` stays low).
- R9: `prechargeOk` is low from the cycle after an accepted write until recovery expires. Recovery is referenced from edge R = k+WL+4 of the last write, including chopped writes. The flag rises in the cycle that begins at edge R + `cfgTwr`.
- R10: `readOk` follows the same rule as R9, with `cfgTwtr` in place of `cfgTwr`.
- R11: After reset, every enable output and both error flags are low, and `prechargeOk` and `readOk` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | WRITE command present this cycle |
| wrCol | input | COL_W | Starting column of the write |
| wrChopBit | input | 1 | A12 of the command (0 = chop when on-the-fly) |
| cfgBurstMode | input | 2 | 00 fixed 8 beats, 01 on-the-fly, 1x reserved |
| cfgTwr | input | CNT_W | Write recovery in clocks |
| cfgTwtr | input | CNT_W | Write-to-read turnaround in clocks |
| dqOe | output | 1 | DQ output enable (a data clock) |
| dqsOe | output | 1 | Strobe output enable |
| preambleEn | output | 1 | Strobe preamble clock |
| postambleEn | output | 1 | Strobe postamble clock |
| beatColRise | output | COL_W | Column of the rising-edge beat |
| beatColFall | output | COL_W | Column of the falling-edge beat |
| prechargeOk | output | 1 | PRECHARGE may be issued |
| readOk | output | 1 | READ may be issued |
| wrReject | output | 1 | Previous-cycle write was too close to the last one |
| modeErr | output | 1 | Previous-cycle write hit a reserved mode |

## Verification
The checker watches the relations between the strobe and data enables on every cycle. Data never appears without the strobe, a preamble never overlaps data, and a postamble only follows a data clock. It also checks that neither ready flag is high while the strobe is driven, that the two error flags never fire together, and that a write under a reserved mode always raises the mode error. The bench scenarios are needed for the per-command timing itself. That covers the exact data clock at the write latency, chop versus full length, column sequences including wrap-around, seamless joining, rejected commands leaving the output untouched, and the clock on which each ready flag returns.

// File: rtl/wbs_pkg.sv
`timescale 1ns/1ps
package wbs_pkg;
  // Strobes from the control half to the column datapath
  typedef struct packed {
    logic load;   // take the column at the end of the latency pipe
    logic step;   // advance to the next data clock of the burst
    logic show;   // current cycle is a data clock
  } dpCtl_t;
endpackage

// File: rtl/wbs_ctrl.sv
`timescale 1ns/1ps
module wbs_ctrl
  import wbs_pkg::*;
#(
  parameter int WL    = 5,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic             wrChopBit,
  input  logic [1:0]       cfgBurstMode,
  input  logic [CNT_W-1:0] cfgTwr,
  input  logic [CNT_W-1:0] cfgTwtr,
  output dpCtl_t           dpCtl,
  output logic             dqOe,
  output logic             dqsOe,
  output logic             preambleEn,
  output logic             postambleEn,
  output logic             prechargeOk,
  output logic             readOk,
  output logic             wrReject,
  output logic             modeErr
);
  localparam int SLOTS = 4;                  // clocks per full-length burst
  localparam int GAP_W = $clog2(SLOTS + 1);
  localparam int SLT_W = $clog2(SLOTS);

  logic             modeReserved, gapOk, accept, isChop;
  logic [GAP_W-1:0] gapCnt;
  logic             pipeVld  [WL];
  logic             pipeChop [WL];
  logic             active, chopCur, lastDq, loadNow, lastSlot, refEdge;
  logic [SLT_W-1:0] slotIdx;
  logic             anyPending;
  logic [CNT_W-1:0] wrCnt, wtrCnt;

  assign modeReserved = cfgBurstMode[1];
  assign gapOk        = (gapCnt >= GAP_W'(SLOTS));
  assign accept       = wrValid && !modeReserved && gapOk;
  assign isChop       = (cfgBurstMode == 2'b01) && !wrChopBit;

  // command spacing tracker, counts edges since the last accepted write
  always_ff @(posedge clk) begin
    if (!rstN)                        gapCnt <= GAP_W'(SLOTS);
    else if (accept)                  gapCnt <= GAP_W'(1);
    else if (gapCnt < GAP_W'(SLOTS))  gapCnt <= gapCnt + GAP_W'(1);
  end

  // latency pipe: one stage per clock of write latency
  genvar g;
  generate
    for (g = 0; g < WL; g++) begin : gStage
      if (g == 0) begin : gHead
        always_ff @(posedge clk) begin
          if (!rstN) begin
            pipeVld[0]  <= 1'b0;
            pipeChop[0] <= 1'b0;
          end else begin
            pipeVld[0]  <= accept;
            pipeChop[0] <= isChop;
          end
        end
      end else begin : gBody
        always_ff @(posedge clk) begin
          if (!rstN) begin
            pipeVld[g]  <= 1'b0;
            pipeChop[g] <= 1'b0;
          end else begin
            pipeVld[g]  <= pipeVld[g-1];
            pipeChop[g] <= pipeChop[g-1];
          end
        end
      end
    end
  endgenerate

  always_comb begin
    anyPending = 1'b0;
    for (int i = 0; i < WL; i++) anyPending = anyPending | pipeVld[i];
  end

  assign loadNow  = pipeVld[WL-1];
  assign lastSlot = active && (slotIdx == SLT_W'(SLOTS - 1));
  assign refEdge  = lastSlot && !loadNow;

  // burst slot engine; a chopped burst still walks all four slots
  always_ff @(posedge clk) begin
    if (!rstN) begin
      active  <= 1'b0;
      slotIdx <= '0;
      chopCur <= 1'b0;
    end else if (loadNow) begin
      active  <= 1'b1;
      slotIdx <= '0;
      chopCur <= pipeChop[WL-1];
    end else if (active) begin
      if (lastSlot) active  <= 1'b0;
      else          slotIdx <= slotIdx + SLT_W'(1);
    end
  end

  assign dqOe        = active && (!chopCur || (slotIdx < SLT_W'(2)));
  assign preambleEn  = loadNow && !dqOe;
  assign postambleEn = lastDq && !dqOe;
  assign dqsOe       = dqOe || preambleEn || postambleEn;

  always_ff @(posedge clk) begin
    if (!rstN) lastDq <= 1'b0;
    else       lastDq <= dqOe;
  end

  // recovery and turnaround counters, loaded at the reference edge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt  <= '0;
      wtrCnt <= '0;
    end else if (refEdge) begin
      wrCnt  <= cfgTwr;
      wtrCnt <= cfgTwtr;
    end else begin
      if (wrCnt  != '0) wrCnt  <= wrCnt  - CNT_W'(1);
      if (wtrCnt != '0) wtrCnt <= wtrCnt - CNT_W'(1);
    end
  end

  assign prechargeOk = !anyPending && !active && (wrCnt  == '0);
  assign readOk      = !anyPending && !active && (wtrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrReject <= 1'b0;
      modeErr  <= 1'b0;
    end else begin
      wrReject <= wrValid && !modeReserved && !gapOk;
      modeErr  <= wrValid && modeReserved;
    end
  end

  assign dpCtl.load = loadNow;
  assign dpCtl.step = active && !lastSlot && !loadNow;
  assign dpCtl.show = dqOe;
endmodule

// File: rtl/wbs_data.sv
`timescale 1ns/1ps
module wbs_data
  import wbs_pkg::*;
#(
  parameter int WL    = 5,
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [COL_W-1:0] wrCol,
  input  dpCtl_t           dpCtl,
  output logic [COL_W-1:0] beatColRise,
  output logic [COL_W-1:0] beatColFall
);
  logic [COL_W-1:0] colPipe [WL];
  logic [COL_W-1:0] curCol;

  genvar g;
  generate
    for (g = 0; g < WL; g++) begin : gCol
      if (g == 0) begin : gHead
        always_ff @(posedge clk) begin
          if (!rstN) colPipe[0] <= '0;
          else       colPipe[0] <= wrCol;
        end
      end else begin : gBody
        always_ff @(posedge clk) begin
          if (!rstN) colPipe[g] <= '0;
          else       colPipe[g] <= colPipe[g-1];
        end
      end
    end
  endgenerate

  // two beats per clock: advance the column by two each data clock
  always_ff @(posedge clk) begin
    if (!rstN)           curCol <= '0;
    else if (dpCtl.load) curCol <= colPipe[WL-1];
    else if (dpCtl.step) curCol <= curCol + COL_W'(2);
  end

  assign beatColRise = dpCtl.show ? curCol                 : '0;
  assign beatColFall = dpCtl.show ? curCol + COL_W'(1)     : '0;
endmodule

// File: rtl/wr_burst_sched.sv
`timescale 1ns/1ps
module wr_burst_sched
  import wbs_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int CWL   = 5,
  parameter int AL    = 0,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrValid,
  input  logic [COL_W-1:0] wrCol,
  input  logic             wrChopBit,
  input  logic [1:0]       cfgBurstMode,
  input  logic [CNT_W-1:0] cfgTwr,
  input  logic [CNT_W-1:0] cfgTwtr,
  output logic             dqOe,
  output logic             dqsOe,
  output logic             preambleEn,
  output logic             postambleEn,
  output logic [COL_W-1:0] beatColRise,
  output logic [COL_W-1:0] beatColFall,
  output logic             prechargeOk,
  output logic             readOk,
  output logic             wrReject,
  output logic             modeErr
);
  localparam int WL = CWL + AL;

  dpCtl_t dpCtl;

  wbs_ctrl #(.WL(WL), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrChopBit(wrChopBit),
    .cfgBurstMode(cfgBurstMode), .cfgTwr(cfgTwr), .cfgTwtr(cfgTwtr),
    .dpCtl(dpCtl), .dqOe(dqOe), .dqsOe(dqsOe), .preambleEn(preambleEn),
    .postambleEn(postambleEn), .prechargeOk(prechargeOk), .readOk(readOk),
    .wrReject(wrReject), .modeErr(modeErr)
  );

  wbs_data #(.WL(WL), .COL_W(COL_W)) uData (
    .clk(clk), .rstN(rstN), .wrCol(wrCol), .dpCtl(dpCtl),
    .beatColRise(beatColRise), .beatColFall(beatColFall)
  );
endmodule

// File: rtl/wbs_chk.sv
`timescale 1ns/1ps
module wbs_chk #(
  parameter int COL_W = 10,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrValid,
  input logic [COL_W-1:0] wrCol,
  input logic             wrChopBit,
  input logic [1:0]       cfgBurstMode,
  input logic [CNT_W-1:0] cfgTwr,
  input logic [CNT_W-1:0] cfgTwtr,
  input logic             dqOe,
  input logic             dqsOe,
  input logic             preambleEn,
  input logic             postambleEn,
  input logic [COL_W-1:0] beatColRise,
  input logic [COL_W-1:0] beatColFall,
  input logic             prechargeOk,
  input logic             readOk,
  input logic             wrReject,
  input logic             modeErr
);
  assert_data_has_strobe_R5: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> dqsOe);
  assert_preamble_not_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    preambleEn |-> !dqOe);
  assert_postamble_after_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    postambleEn |-> $past(dqOe));
  assert_no_pre_ok_while_driving_R9: assert property (@(posedge clk) disable iff (!rstN)
    prechargeOk |-> !dqsOe);
  assert_no_read_ok_while_driving_R10: assert property (@(posedge clk) disable iff (!rstN)
    readOk |-> !dqsOe);
  assert_errors_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(modeErr && wrReject));
  assert_reserved_mode_flags_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && cfgBurstMode[1]) |=> modeErr);
endmodule

bind wr_burst_sched wbs_chk #(.COL_W(COL_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrCol(wrCol), .wrChopBit(wrChopBit),
  .cfgBurstMode(cfgBurstMode), .cfgTwr(cfgTwr), .cfgTwtr(cfgTwtr), .dqOe(dqOe),
  .dqsOe(dqsOe), .preambleEn(preambleEn), .postambleEn(postambleEn),
  .beatColRise(beatColRise), .beatColFall(beatColFall), .prechargeOk(prechargeOk),
  .readOk(readOk), .wrReject(wrReject), .modeErr(modeErr)
);

// File: tb/sim_wr_burst_sched.sv
`timescale 1ns/1ps
module sim_wr_burst_sched;
  localparam int COL_W = 10;
  localparam int CNT_W = 5;
  localparam int WL    = 5;
  localparam int TWR   = 6;
  localparam int TWTR  = 3;
  localparam int DEPTH = 2048;
  localparam int CMASK = (1 << COL_W) - 1;

  logic clk = 1'b0;
  logic rstN, wrValid, wrChopBit;
  logic [COL_W-1:0] wrCol;
  logic [1:0] cfgBurstMode;
  logic [CNT_W-1:0] cfgTwr, cfgTwtr;
  logic dqOe, dqsOe, preambleEn, postambleEn, prechargeOk, readOk, wrReject, modeErr;
  logic [COL_W-1:0] beatColRise, beatColFall;

  always #2.5 clk = ~clk;

  wr_burst_sched #(.COL_W(COL_W), .CWL(5), .AL(0), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrCol(wrCol), .wrChopBit(wrChopBit),
    .cfgBurstMode(cfgBurstMode), .cfgTwr(cfgTwr), .cfgTwtr(cfgTwtr), .dqOe(dqOe),
    .dqsOe(dqsOe), .preambleEn(preambleEn), .postambleEn(postambleEn),
    .beatColRise(beatColRise), .beatColFall(beatColFall), .prechargeOk(prechargeOk),
    .readOk(readOk), .wrReject(wrReject), .modeErr(modeErr)
  );

  typedef struct { int cyc; int rise; int fall; } beat_t;
  beat_t beatQ[$];

  bit expDq [DEPTH];
  bit expPok[DEPTH];
  bit expRok[DEPTH];
  bit expRej[DEPTH];
  bit expMod[DEPTH];

  int    cyc = 0;
  int    nCmp = 0, nErr = 0;
  int    lastAcc = -100;
  bit    monOn = 0;
  string scenTag = "R11";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input int act, input int exp, input string what);
    nCmp++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", what, cyc, act, exp);
    end
  endtask

  // driver: issues one command and records what it must produce
  task automatic issue(input int col, input bit a12);
    int k;
    int n;
    bit chop;
    @(negedge clk);
    wrValid = 1'b1; wrCol = COL_W'(col); wrChopBit = a12;
    k = cyc + 1;
    if (cfgBurstMode[1]) expMod[k] = 1'b1;
    else if (k - lastAcc < 4) expRej[k] = 1'b1;
    else begin
      lastAcc = k;
      chop = (cfgBurstMode == 2'b01) && !a12;
      n = chop ? 2 : 4;
      for (int i = 0; i < n; i++) begin
        expDq[k+WL+i] = 1'b1;
        beatQ.push_back('{k+WL+i, (col + 2*i) & CMASK, (col + 2*i + 1) & CMASK});
      end
      for (int c = k; c < k+WL+4+TWR;  c++) expPok[c] = 1'b0;
      for (int c = k; c < k+WL+4+TWTR; c++) expRok[c] = 1'b0;
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares every output each cycle against the expectation
  always @(negedge clk) begin
    if (monOn && cyc + 1 < DEPTH) begin
      int c;
      bit pre, post;
      beat_t b;
      c = cyc;
      pre  = expDq[c+1] && !expDq[c];
      post = (c > 0) && expDq[c-1] && !expDq[c];
      chk(int'(dqOe), int'(expDq[c]), {scenTag, " R1 dqOe"});
      chk(int'(preambleEn), int'(pre), {scenTag, " R5 preambleEn"});
      chk(int'(postambleEn), int'(post), {scenTag, " R5 postambleEn"});
      chk(int'(dqsOe), int'(expDq[c] | pre | post), {scenTag, " R5 dqsOe"});
      chk(int'(prechargeOk), int'(expPok[c]), {scenTag, " R9 prechargeOk"});
      chk(int'(readOk), int'(expRok[c]), {scenTag, " R10 readOk"});
      chk(int'(wrReject), int'(expRej[c]), {scenTag, " R7 wrReject"});
      chk(int'(modeErr), int'(expMod[c]), {scenTag, " R8 modeErr"});
      if (beatQ.size() > 0 && beatQ[0].cyc == c) begin
        b = beatQ.pop_front();
        chk(int'(beatColRise), b.rise, {scenTag, " R4 beatColRise"});
        chk(int'(beatColFall), b.fall, {scenTag, " R4 beatColFall"});
      end else if (!expDq[c]) begin
        chk(int'(beatColRise), 0, {scenTag, " R4 idle rise"});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    nCmp++; nErr++;
    $display("FAIL watchdog: actual running expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      expDq[i] = 0; expPok[i] = 1; expRok[i] = 1; expRej[i] = 0; expMod[i] = 0;
    end
    rstN = 1'b0; wrValid = 1'b0; wrCol = '0; wrChopBit = 1'b0;
    cfgBurstMode = 2'b00; cfgTwr = CNT_W'(TWR); cfgTwtr = CNT_W'(TWTR);
    idle(3);
    rstN = 1'b1;
    idle(1);
    // R11 reset state
    chk(int'(dqsOe), 0, "R11 dqsOe");
    chk(int'(dqOe), 0, "R11 dqOe");
    chk(int'(prechargeOk), 1, "R11 prechargeOk");
    chk(int'(readOk), 1, "R11 readOk");
    chk(int'(wrReject | modeErr), 0, "R11 error flags");
    monOn = 1;

    scenTag = "R2 fixed BL8";        issue(16, 1'b0);  idle(30);
    cfgBurstMode = 2'b01;
    scenTag = "R3 chop";             issue(40, 1'b0);  idle(30);
    scenTag = "R3 otf BL8";          issue(100, 1'b1); idle(30);
    cfgBurstMode = 2'b00;
    scenTag = "R6 seamless";         issue(200, 1'b0); idle(2); issue(208, 1'b0); idle(30);
    scenTag = "R7 too close";        issue(300, 1'b0); issue(500, 1'b0); issue(308, 1'b0); idle(30);
    scenTag = "R7 one short";        issue(320, 1'b0); idle(1); issue(600, 1'b0); idle(30);
    cfgBurstMode = 2'b10;
    scenTag = "R8 reserved 10";      issue(50, 1'b1);  idle(10);
    cfgBurstMode = 2'b11;
    scenTag = "R8 reserved 11";      issue(60, 1'b0);  idle(10);
    cfgBurstMode = 2'b00;
    scenTag = "R4 column wrap";      issue(1020, 1'b0); idle(30);
    cfgBurstMode = 2'b01;
    scenTag = "R5 chop then BL8";    issue(700, 1'b0); idle(2); issue(720, 1'b1); idle(30);
    scenTag = "R9 chop recovery";    issue(800, 1'b0); idle(2); issue(804, 1'b0); idle(30);

    monOn = 0;
    if (beatQ.size() != 0) chk(beatQ.size(), 0, "R4 beats left unseen");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
    $finish;
  end
endmodule